// File: doc/BRIEF.md
# Redistributor Region Address Mapper

This block keeps a small table of redistributor regions. Each region is registered by writing one 64-bit descriptor. The descriptor carries four fields: a base address, a count of redistributor frames, a reserved flag nibble and a region index. The block checks every descriptor as it arrives. It stores the good ones and returns an error code for the rest. Regions must be registered in order, starting at index 0 and adding one at a time. Software can read back any registered region by its index.

CPUs are placed into frames by walking the regions in index order:

- The first region takes CPUs 0 up to its count minus one.
- The next region continues the numbering from there, and so on.
- Each frame occupies 128 KB, and frames within a region are packed one after another with no gaps.

A combinational lookup port turns a CPU index into the address of that CPU's frame and reports which region holds it. A coverage flag shows whether the registered frames are enough for the configured number of CPUs.

Top module: `redist_region_mapper`

## Requirements
- R1: Descriptor layout: index in bits [11:0], reserved flags in [15:12], base address bits [51:16] in [51:16], frame count in [63:52]. The block accepts a write that passes every check, stores it, and answers with `resp_valid` high and `resp_err` = 0 (OK) one cycle later.
- R2: A write with any flag bit set is rejected with `resp_err` = 1 (invalid) and is not stored. This check has the highest priority, together with R3.
- R3: A write with a frame count of zero is rejected with `resp_err` = 1 (invalid) and is not stored.
- R4: The index of a write must equal the number of regions already registered. A smaller index returns 2 (exists). A larger index returns 1 (invalid). Neither is stored.
- R5: Once 8 regions are registered, every further write returns 2 (exists) and the table stays unchanged. This outranks the index check of R4.
- R6: Address bits at or above PA_W (48 by default, so descriptor bits [51:48]) must be zero. Otherwise the write returns 4 (out of range) and is not stored. This check has the lowest priority.
- R7: A read of a registered index returns the stored descriptor on `rd_desc` with `resp_err` = 0. A read of an unregistered index returns `resp_err` = 3 (not found) and `rd_desc` = 0. Both answers come one cycle after the request.
- R8: For CPU n, the lookup selects the first region r whose running sum of counts exceeds n. Let S be the sum of the counts of the regions before r. The lookup reports `lk_hit` = 1, `lk_region` = r and `lk_addr` = base×65536 + (n − S)×131072, all combinationally.
- R9: A CPU index at or beyond the total registered count gives `lk_hit` = 0, `lk_addr` = 0 and `lk_region` = 0.
- R10: `cov_ready` is 1 exactly when the total registered count is at least `cpu_count`.
- R11: When a write and a read are requested in the same cycle, only the write is served. The response carries the write's code and `rd_desc` = 0.
- R12: Reset empties the table. After reset, a read of index 0 returns not found, and lookups miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register the descriptor on `wr_desc` |
| wr_desc | input | 64 | Descriptor to register |
| rd_en | input | 1 | Read back the region selected by `rd_idx` |
| rd_idx | input | 12 | Region index to read |
| resp_valid | output | 1 | One-cycle pulse marking a response |
| resp_err | output | 3 | Response code: 0 OK, 1 invalid, 2 exists, 3 not found, 4 out of range |
| rd_desc | output | 64 | Descriptor returned by a read |
| lk_cpu | input | CPU_W | CPU index to look up |
| lk_hit | output | 1 | The CPU index falls inside a registered region |
| lk_region | output | $clog2(NREG) | Region that holds the CPU |
| lk_addr | output | 64 | Base address of the CPU's frame |
| cpu_count | input | CPU_W+1 | Configured number of CPUs |
| cov_ready | output | 1 | Registered frames cover `cpu_count` |

## Verification
The bench targets the following corner cases:

- **Check priority.** It sends descriptors that break several rules at once: reserved flags with a bad index, and a full table with out-of-range bases. A design that ordered its checks wrongly would report exists or out of range where invalid is due.
- **Index order.** It sends indices just below, just above and equal to the registered count. A design with an off-by-one would store duplicates or skip a slot.
- **Region boundaries.** Lookups hit the first and last CPU of every region and the first CPU past the total. A wrong prefix sum would return the neighbouring region or a frame 128 KB off.
- **Write and read together.** A design that let the read through in that cycle would show a stale descriptor on `rd_desc`.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    localparam int DESC_W      = 64;
    localparam int CNT_W       = 12;
    localparam int BASE_W      = 36;
    localparam int FLG_W       = 4;
    localparam int IDX_W       = 12;
    localparam int BASE_SHIFT  = 16;
    localparam int FRAME_SHIFT = 17;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [BASE_W-1:0] base;
        logic [FLG_W-1:0]  flags;
        logic [IDX_W-1:0]  idx;
    } rgn_desc_t;

    typedef enum logic [2:0] {
        ERR_OK       = 3'd0,
        ERR_INVALID  = 3'd1,
        ERR_EXISTS   = 3'd2,
        ERR_NOTFOUND = 3'd3,
        ERR_RANGE    = 3'd4
    } err_e;

    function automatic logic [63:0] frame_addr(logic [BASE_W-1:0] base,
                                               logic [CNT_W-1:0]  slot);
        return {12'b0, base, 16'b0} + (64'(slot) << FRAME_SHIFT);
    endfunction

endpackage

// File: rtl/rrm_desc_check.sv
module rrm_desc_check
    import rrm_pkg::*;
#(
    parameter int NREG = 8,
    parameter int PA_W = 48,
    localparam int NCNT_W = $clog2(NREG + 1)
) (
    input  rgn_desc_t         desc,
    input  logic [NCNT_W-1:0] nreg,
    output err_e              verdict
);
    localparam logic [BASE_W-1:0] HI_MASK =
        ~((BASE_W'(1) << (PA_W - BASE_SHIFT)) - BASE_W'(1));

    logic bad_field;
    logic full;
    logic idx_low;
    logic idx_high;
    logic range_bad;

    assign bad_field = (desc.flags != '0) || (desc.count == '0);
    assign full      = (32'(nreg) == NREG);
    assign idx_low   = 32'(desc.idx) < 32'(nreg);
    assign idx_high  = 32'(desc.idx) > 32'(nreg);
    assign range_bad = |(desc.base & HI_MASK);

    always_comb begin
        verdict = ERR_OK;
        if (bad_field)
            verdict = ERR_INVALID;
        else if (full || idx_low)
            verdict = ERR_EXISTS;
        else if (idx_high)
            verdict = ERR_INVALID;
        else if (range_bad)
            verdict = ERR_RANGE;
    end

endmodule

// File: rtl/rrm_region_table.sv
module rrm_region_table
    import rrm_pkg::*;
#(
    parameter int NREG = 8,
    localparam int NCNT_W = $clog2(NREG + 1),
    localparam int SLOT_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_accept,
    input  rgn_desc_t         wr_desc,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_hit,
    output rgn_desc_t         rd_data,
    output logic [NCNT_W-1:0] nreg,
    output rgn_desc_t         tbl [NREG]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            nreg <= '0;
            for (int r = 0; r < NREG; r++)
                tbl[r] <= '0;
        end else if (wr_accept) begin
            tbl[nreg[SLOT_W-1:0]] <= wr_desc;
            nreg <= nreg + NCNT_W'(1);
        end
    end

    assign rd_hit  = 32'(rd_idx) < 32'(nreg);
    assign rd_data = rd_hit ? tbl[rd_idx[SLOT_W-1:0]] : '0;

    // R5: the table never holds more than NREG regions
    a_r5_bounded: assert property (@(posedge clk) disable iff (rst)
        32'(nreg) <= NREG);

    // R1: an accepted write grows the table by exactly one
    a_r1_grow: assert property (@(posedge clk) disable iff (rst)
        wr_accept |=> nreg == $past(nreg) + NCNT_W'(1));

    // R4: the table never grows without an accepted write
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_accept |=> $stable(nreg));

endmodule

// File: rtl/rrm_cpu_lookup.sv
module rrm_cpu_lookup
    import rrm_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int CPU_W = 12,
    localparam int NCNT_W = $clog2(NREG + 1),
    localparam int SLOT_W = $clog2(NREG),
    localparam int TOT_W  = CNT_W + $clog2(NREG) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  rgn_desc_t         tbl [NREG],
    input  logic [NCNT_W-1:0] nreg,
    input  logic [CPU_W-1:0]  cpu,
    output logic              hit,
    output logic [SLOT_W-1:0] region,
    output logic [63:0]       addr,
    output logic [TOT_W-1:0]  total
);
    logic [TOT_W-1:0] cum [NREG+1];
    logic [NREG-1:0]  sel;

    assign cum[0] = '0;

    for (genvar r = 0; r < NREG; r++) begin : g_rgn
        logic valid;
        assign valid      = r < 32'(nreg);
        assign cum[r+1]   = cum[r] + (valid ? TOT_W'(tbl[r].count) : '0);
        assign sel[r]     = valid && (32'(cpu) >= 32'(cum[r]))
                                  && (32'(cpu) <  32'(cum[r+1]));
    end

    assign total = cum[NREG];
    assign hit   = |sel;

    always_comb begin
        addr   = '0;
        region = '0;
        for (int r = 0; r < NREG; r++) begin
            if (sel[r]) begin
                addr   = frame_addr(tbl[r].base, CNT_W'(32'(cpu) - 32'(cum[r])));
                region = SLOT_W'(r);
            end
        end
    end

    // R8: at most one region claims a CPU
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R9: a hit only occurs below the registered total
    a_r9_in_total: assert property (@(posedge clk) disable iff (rst)
        hit |-> 32'(cpu) < 32'(total));

endmodule

// File: rtl/redist_region_mapper.sv
module redist_region_mapper
    import rrm_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int PA_W  = 48,
    parameter int CPU_W = 12,
    localparam int NCNT_W = $clog2(NREG + 1),
    localparam int SLOT_W = $clog2(NREG),
    localparam int TOT_W  = CNT_W + $clog2(NREG) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [63:0]       wr_desc,
    input  logic              rd_en,
    input  logic [11:0]       rd_idx,
    output logic              resp_valid,
    output logic [2:0]        resp_err,
    output logic [63:0]       rd_desc,
    input  logic [CPU_W-1:0]  lk_cpu,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_region,
    output logic [63:0]       lk_addr,
    input  logic [CPU_W:0]    cpu_count,
    output logic              cov_ready
);
    rgn_desc_t         in_desc;
    err_e              verdict;
    logic              wr_accept;
    logic [NCNT_W-1:0] nreg;
    rgn_desc_t         tbl [NREG];
    logic              rd_hit;
    rgn_desc_t         rd_data;
    logic [TOT_W-1:0]  total;

    assign in_desc   = rgn_desc_t'(wr_desc);
    assign wr_accept = wr_en && (verdict == ERR_OK);

    rrm_desc_check #(.NREG(NREG), .PA_W(PA_W)) u_check (
        .desc    (in_desc),
        .nreg    (nreg),
        .verdict (verdict)
    );

    rrm_region_table #(.NREG(NREG)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_accept (wr_accept),
        .wr_desc   (in_desc),
        .rd_idx    (rd_idx),
        .rd_hit    (rd_hit),
        .rd_data   (rd_data),
        .nreg      (nreg),
        .tbl       (tbl)
    );

    rrm_cpu_lookup #(.NREG(NREG), .CPU_W(CPU_W)) u_lookup (
        .clk    (clk),
        .rst    (rst),
        .tbl    (tbl),
        .nreg   (nreg),
        .cpu    (lk_cpu),
        .hit    (lk_hit),
        .region (lk_region),
        .addr   (lk_addr),
        .total  (total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_err   <= ERR_OK;
            rd_desc    <= '0;
        end else begin
            resp_valid <= wr_en || rd_en;
            if (wr_en) begin
                resp_err <= verdict;
                rd_desc  <= '0;
            end else if (rd_en) begin
                resp_err <= rd_hit ? ERR_OK : ERR_NOTFOUND;
                rd_desc  <= rd_data;
            end
        end
    end

    assign cov_ready = 32'(total) >= 32'(cpu_count);

    // R2: reserved flag bits force an invalid response
    a_r2_flags: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_desc[15:12] != 4'd0) |=> resp_valid && resp_err == ERR_INVALID);

    // R3: a zero count forces an invalid response
    a_r3_zero_count: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_desc[63:52] == 12'd0) |=> resp_err == ERR_INVALID);

    // R11: a write shadows a simultaneous read
    a_r11_wr_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> rd_desc == 64'd0);

    // R7: reading past the registered regions reports not found
    a_r7_notfound: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && 32'(rd_idx) >= 32'(nreg)) |=> resp_err == ERR_NOTFOUND);

    // R10: coverage of a nonzero CPU count needs at least one region
    a_r10_cov: assert property (@(posedge clk) disable iff (rst)
        (cov_ready && cpu_count != '0) |-> nreg != '0);

endmodule

// File: tb/redist_region_mapper_bench.sv
module redist_region_mapper_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_desc = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_idx = '0;
    logic        resp_valid;
    logic [2:0]  resp_err;
    logic [63:0] rd_desc;
    logic [11:0] lk_cpu = '0;
    logic        lk_hit;
    logic [2:0]  lk_region;
    logic [63:0] lk_addr;
    logic [12:0] cpu_count = 13'd1;
    logic        cov_ready;

    redist_region_mapper u_redist_region_mapper (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_desc(wr_desc),
        .rd_en(rd_en), .rd_idx(rd_idx), .resp_valid(resp_valid),
        .resp_err(resp_err), .rd_desc(rd_desc), .lk_cpu(lk_cpu),
        .lk_hit(lk_hit), .lk_region(lk_region), .lk_addr(lk_addr),
        .cpu_count(cpu_count), .cov_ready(cov_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] m_desc [NREG];
    int          m_n = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(int cnt, logic [35:0] base, int flg, int idx);
        return {12'(cnt), base, 4'(flg), 12'(idx)};
    endfunction

    function automatic int exp_err(logic [63:0] d);
        if (d[15:12] != 0 || d[63:52] == 0) return 1;
        if (m_n == NREG || int'(d[11:0]) < m_n) return 2;
        if (int'(d[11:0]) > m_n) return 1;
        if (d[51:48] != 0) return 4;
        return 0;
    endfunction

    function automatic int m_total();
        int t = 0;
        for (int r = 0; r < m_n; r++) t += int'(m_desc[r][63:52]);
        return t;
    endfunction

    task automatic do_write(logic [63:0] d, bit with_rd, logic [11:0] ri);
        int e;
        e = exp_err(d);
        @(negedge clk);
        wr_en = 1'b1; wr_desc = d; rd_en = with_rd; rd_idx = ri;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk(resp_valid == 1'b1, "R1", "write resp_valid", 64'(resp_valid), 64'd1);
        chk(int'(resp_err) == e, "R2/R3/R4/R5/R6", "write code", 64'(resp_err), 64'(e));
        if (with_rd)
            chk(rd_desc == 64'd0, "R11", "rd_desc on shared cycle", rd_desc, 64'd0);
        if (e == 0) begin
            m_desc[m_n] = d;
            m_n++;
        end
    endtask

    task automatic do_read(logic [11:0] ri);
        logic [63:0] ed;
        int ee;
        ed = (int'(ri) < m_n) ? m_desc[ri[2:0]] : 64'd0;
        ee = (int'(ri) < m_n) ? 0 : 3;
        @(negedge clk);
        rd_en = 1'b1; rd_idx = ri;
        @(negedge clk);
        rd_en = 1'b0;
        chk(int'(resp_err) == ee, "R7", "read code", 64'(resp_err), 64'(ee));
        chk(rd_desc == ed, "R7", "read data", rd_desc, ed);
    endtask

    task automatic do_lookup(int cpu);
        int acc = 0;
        bit eh = 1'b0;
        int er = 0;
        logic [63:0] ea = '0;
        for (int r = 0; r < m_n; r++) begin
            int c = int'(m_desc[r][63:52]);
            if (!eh && cpu < acc + c) begin
                eh = 1'b1; er = r;
                ea = ({28'd0, m_desc[r][51:16]} << 16) + (64'(cpu - acc) << 17);
            end
            acc += c;
        end
        @(negedge clk);
        lk_cpu = 12'(cpu);
        #1;
        chk(lk_hit == eh, eh ? "R8" : "R9", "lookup hit", 64'(lk_hit), 64'(eh));
        chk(lk_addr == ea, eh ? "R8" : "R9", "lookup addr", lk_addr, ea);
        chk(int'(lk_region) == er, eh ? "R8" : "R9", "lookup region", 64'(lk_region), 64'(er));
    endtask

    task automatic do_cov(int cnt);
        bit e;
        e = m_total() >= cnt;
        @(negedge clk);
        cpu_count = 13'(cnt);
        #1;
        chk(cov_ready == e, "R10", "cov_ready", 64'(cov_ready), 64'(e));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_n = 0;
    endtask

    function automatic logic [63:0] rand_desc();
        int k = int'($urandom % 10);
        int idx = m_n;
        int cnt = 1 + int'($urandom % 6);
        int flg = 0;
        logic [35:0] base = {4'd0, 32'($urandom)};
        case (k)
            0: flg = 1 + int'($urandom % 15);
            1: cnt = 0;
            2: idx = m_n + 1 + int'($urandom % 3);
            3: idx = (m_n > 0) ? int'($urandom % m_n) : 0;
            4: base[35:32] = 4'(1 + $urandom % 15);
            default: ;
        endcase
        return mk(cnt, base, flg, idx);
    endfunction

    task automatic sweep_lookups();
        int acc = 0;
        for (int r = 0; r < m_n; r++) begin
            do_lookup(acc);
            acc += int'(m_desc[r][63:52]);
            do_lookup(acc - 1);
        end
        do_lookup(acc);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_n = 0;

        // R12: empty table after reset
        do_read(12'd0);
        do_lookup(0);
        do_cov(1);

        // directed: priority and order corners
        do_write(mk(4, 36'h1, 2, 3), 1'b0, 12'd0);      // R2 beats R4
        do_write(mk(0, 36'h1, 0, 0), 1'b0, 12'd0);      // R3
        do_write(mk(2, 36'h1, 0, 1), 1'b0, 12'd0);      // R4 high
        do_write(mk(2, 36'hF_0000_0000, 0, 0), 1'b0, 12'd0); // R6
        do_write(mk(3, 36'h10, 0, 0), 1'b0, 12'd0);     // R1 accept
        do_write(mk(3, 36'h10, 0, 0), 1'b0, 12'd0);     // R4 low -> exists
        do_write(mk(1, 36'h40, 0, 1), 1'b1, 12'd0);     // R11 shared cycle
        do_read(12'd1);
        do_read(12'd2);
        for (int i = 2; i < NREG; i++)
            do_write(mk(1 + i % 3, 36'(36'h100 * i), 0, i), 1'b0, 12'd0);
        do_write(mk(2, 36'hF_0000_0000, 0, 8), 1'b0, 12'd0); // R5 beats R6
        do_write(mk(2, 36'h5, 0, 3), 1'b0, 12'd0);           // R5
        sweep_lookups();
        do_cov(m_total());
        do_cov(m_total() + 1);
        do_cov(0);

        // random rounds
        for (int round = 0; round < 4; round++) begin
            do_reset();
            do_read(12'd0);   // R12
            for (int op = 0; op < 40; op++) begin
                int s = int'($urandom % 8);
                if (s < 4)
                    do_write(rand_desc(), 1'b0, 12'd0);
                else if (s == 4)
                    do_write(rand_desc(), 1'b1, 12'($urandom % 9));
                else if (s == 5)
                    do_read(12'($urandom % 10));
                else if (s == 6)
                    do_lookup(int'($urandom % (m_total() + 3)));
                else
                    do_cov(int'($urandom % (m_total() + 3)));
            end
            sweep_lookups();
            for (int i = 0; i < NREG; i++) do_read(12'(i));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule